// File: doc/BRIEF.md
# Increment-and-Skip Instruction Executor

This block executes two single-word instructions of a small 8-bit register-file processor. Both add one to a file register. The first requests a skip of the following instruction when the 8-bit result is zero. The second requests the skip when the result is non-zero. The block decodes the word, builds a 12-bit data address from the access bit, the bank register and the 8-bit file field, and runs every instruction cycle as four clock phases. The word is captured in the first phase, the register is read in the second, the sum is formed in the third, and the destination is written in the fourth. The destination is either the working register or the file register itself.

When a skip is taken, the word the fetch stage has already delivered is thrown away and its cycle runs as a no-operation. If that discarded word opens a two-word instruction, its second word also runs as a no-operation, so a skip costs one or two extra instruction cycles. The register file is an internal array. A load port lets the rest of the datapath place values in it.

Top module: `incskip_exec`

## Requirements
- R1: Only words with bits 15..10 = 001111 (skip on zero) or 010010 (skip on non-zero) execute. Any other word asserts neither `file_we` nor `skip_req` and leaves `w_reg` unchanged.
- R2: The result is the addressed register plus one, modulo 256. With bit 9 (d) = 1, `file_we` is high in phase 3, with `file_wdata` = result and `w_reg` unchanged. With d = 0, `file_we` stays low and `w_reg` holds the result from the following phase 0.
- R3: With bit 8 (a) = 1, `file_addr` = {`bank_sel`, bits 7..0}, using the `bank_sel` value sampled in phase 0.
- R4: With a = 0, `bank_sel` is ignored. A file field below 0x80 maps to bank 0, and 0x80 or above maps to bank 0xF.
- R5: `phase` counts 0,1,2,3 repeatedly from reset. `file_we` and `skip_req` are asserted only in phase 3.
- R6: The skip-on-zero instruction raises `skip_req` in phase 3 exactly when the 8-bit result is 0x00, which includes a register holding 0xFF.
- R7: The skip-on-non-zero instruction raises `skip_req` in phase 3 exactly when the 8-bit result is not 0x00.
- R8: After a skip, the next instruction cycle is a no-operation. `slot_nop` is high for all four of its phases, and the word presented in it writes nothing and requests no skip.
- R9: If the discarded word has bits 15..12 = 1100 (a two-word instruction), a second no-operation cycle follows in which the word presented is not executed. The cycle after that executes normally.
- R10: While reset is held, `phase` = 0, `w_reg` = 0x00, and `file_we`, `skip_req` and `slot_nop` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_word | input | 16 | Instruction word from fetch, sampled at the end of phase 0 |
| bank_sel | input | BANK_W | Bank register value |
| ld_en | input | 1 | Load strobe into the register file |
| ld_addr | input | BANK_W+8 | Load address |
| ld_data | input | 8 | Load data |
| phase | output | 2 | Current phase, 0..3 |
| slot_nop | output | 1 | Current instruction cycle is a forced no-operation |
| skip_req | output | 1 | Discard-prefetched-word request to fetch |
| file_we | output | 1 | File register write in this phase |
| file_addr | output | BANK_W+8 | Data address of the executing instruction |
| file_wdata | output | 8 | Incremented result |
| w_reg | output | 8 | Working register |

## Verification
The bench builds the block with its default parameters: a 4-bit bank field, a 12-bit address space, an access-bank split at 0x80 and a two-word prefix of 1100. These values make both ends of the access bank (0x7F and 0x80) reachable. They also let the top address 0xFFF be reached through the bank register, and they let a skip land on a two-word word whose second word itself looks like an executable increment.

// File: rtl/incskip_pkg.sv
package incskip_pkg;

    localparam int DATA_W = 8;
    localparam int F_W    = 8;
    localparam int WORD_W = 16;

    localparam logic [5:0] OPC_INC_SKZ  = 6'b001111;
    localparam logic [5:0] OPC_INC_SKNZ = 6'b010010;

    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_e;

    typedef enum logic {
        SK_ON_ZERO    = 1'b0,
        SK_ON_NONZERO = 1'b1
    } sense_e;

    typedef struct packed {
        logic            hit;
        sense_e          sense;
        logic            to_file;
        logic            use_bank;
        logic [F_W-1:0]  f;
    } dec_t;

    function automatic dec_t decode_word(input logic [WORD_W-1:0] w);
        dec_t d;
        d.hit      = (w[15:10] == OPC_INC_SKZ) || (w[15:10] == OPC_INC_SKNZ);
        d.sense    = (w[15:10] == OPC_INC_SKNZ) ? SK_ON_NONZERO : SK_ON_ZERO;
        d.to_file  = w[9];
        d.use_bank = w[8];
        d.f        = w[7:0];
        return d;
    endfunction

    function automatic logic skip_taken(input sense_e s, input logic [DATA_W-1:0] r);
        return (s == SK_ON_ZERO) ? (r == '0) : (r != '0);
    endfunction

    function automatic logic prefix_match(input logic [WORD_W-1:0] w,
                                          input logic [WORD_W-1:0] mask,
                                          input logic [WORD_W-1:0] value);
        return (w & mask) == value;
    endfunction

endpackage

// File: rtl/incskip_decode.sv
module incskip_decode
    import incskip_pkg::*;
#(
    parameter int          BANK_W    = 4,
    parameter logic [7:0]  ACC_SPLIT = 8'h80
) (
    input  logic [WORD_W-1:0]       word,
    input  logic [BANK_W-1:0]       bank_sel,
    output dec_t                    dec,
    output logic [BANK_W+F_W-1:0]   addr
);
    logic [BANK_W-1:0] bank;

    always_comb begin
        dec = decode_word(word);
        if (dec.use_bank)
            bank = bank_sel;
        else if (dec.f < ACC_SPLIT)
            bank = '0;
        else
            bank = '1;
        addr = {bank, dec.f};
    end
endmodule

// File: rtl/incskip_rf.sv
module incskip_rf #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr] <= wr_data;
        else if (ld_en)
            mem[ld_addr] <= ld_data;
        if (rd_en)
            rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/incskip_seq.sv
module incskip_seq
    import incskip_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   hit,
    input  logic   two_word,
    input  logic   skip_now,
    output phase_e phase,
    output logic   issue,
    output logic   active,
    output logic   slot_nop
);
    phase_e ph_q;
    logic   skip_pend;
    logic   tail_pend;
    logic   nop_q;
    logic   act_q;

    assign phase    = ph_q;
    assign active   = act_q;
    assign issue    = (ph_q == PH_Q1) && !skip_pend && !tail_pend;
    assign slot_nop = (ph_q == PH_Q1) ? (skip_pend | tail_pend) : nop_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q      <= PH_Q1;
            skip_pend <= 1'b0;
            tail_pend <= 1'b0;
            nop_q     <= 1'b0;
            act_q     <= 1'b0;
        end else begin
            ph_q <= phase_e'(ph_q + 2'd1);
            if (ph_q == PH_Q1) begin
                if (skip_pend) begin
                    nop_q     <= 1'b1;
                    act_q     <= 1'b0;
                    skip_pend <= 1'b0;
                    tail_pend <= two_word;
                end else if (tail_pend) begin
                    nop_q     <= 1'b1;
                    act_q     <= 1'b0;
                    tail_pend <= 1'b0;
                end else begin
                    nop_q     <= 1'b0;
                    act_q     <= hit;
                end
            end
            if (ph_q == PH_Q4 && skip_now)
                skip_pend <= 1'b1;
        end
    end
endmodule

// File: rtl/incskip_exec.sv
module incskip_exec
    import incskip_pkg::*;
#(
    parameter int          BANK_W    = 4,
    parameter logic [7:0]  ACC_SPLIT = 8'h80,
    parameter logic [15:0] TW_MASK   = 16'hF000,
    parameter logic [15:0] TW_VALUE  = 16'hC000
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [15:0]             instr_word,
    input  logic [BANK_W-1:0]       bank_sel,
    input  logic                    ld_en,
    input  logic [BANK_W+7:0]       ld_addr,
    input  logic [7:0]              ld_data,
    output logic [1:0]              phase,
    output logic                    slot_nop,
    output logic                    skip_req,
    output logic                    file_we,
    output logic [BANK_W+7:0]       file_addr,
    output logic [7:0]              file_wdata,
    output logic [7:0]              w_reg
);
    localparam int ADDR_W = BANK_W + F_W;

    dec_t              dec_w, dec_q;
    logic [ADDR_W-1:0] addr_w, addr_q;
    logic [DATA_W-1:0] rdata, result_q, w_q;
    phase_e            ph;
    logic              issue, active, skip_now, rd_en, two_word;

    incskip_decode #(.BANK_W(BANK_W), .ACC_SPLIT(ACC_SPLIT)) u_dec (
        .word     (instr_word),
        .bank_sel (bank_sel),
        .dec      (dec_w),
        .addr     (addr_w)
    );

    assign two_word = prefix_match(instr_word, TW_MASK, TW_VALUE);

    incskip_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .hit      (dec_w.hit),
        .two_word (two_word),
        .skip_now (skip_now),
        .phase    (ph),
        .issue    (issue),
        .active   (active),
        .slot_nop (slot_nop)
    );

    assign rd_en    = (ph == PH_Q2) && active;
    assign skip_now = (ph == PH_Q4) && active && skip_taken(dec_q.sense, result_q);
    assign file_we  = (ph == PH_Q4) && active && dec_q.to_file;

    incskip_rf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rf (
        .clk     (clk),
        .rd_en   (rd_en),
        .rd_addr (addr_q),
        .rd_data (rdata),
        .wr_en   (file_we),
        .wr_addr (addr_q),
        .wr_data (result_q),
        .ld_en   (ld_en),
        .ld_addr (ld_addr),
        .ld_data (ld_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q    <= '0;
            addr_q   <= '0;
            result_q <= '0;
            w_q      <= '0;
        end else begin
            if (issue) begin
                dec_q  <= dec_w;
                addr_q <= addr_w;
            end
            if (ph == PH_Q3 && active)
                result_q <= rdata + 8'd1;
            if (ph == PH_Q4 && active && !dec_q.to_file)
                w_q <= result_q;
        end
    end

    assign phase      = ph;
    assign skip_req   = skip_now;
    assign file_addr  = addr_q;
    assign file_wdata = result_q;
    assign w_reg      = w_q;
endmodule

// File: rtl/incskip_chk.sv
module incskip_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] phase,
    input logic       slot_nop,
    input logic       skip_req,
    input logic       file_we,
    input logic [7:0] w_reg
);
    // R5: the phase counter advances by one each clock
    a_r5_phase_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (phase == $past(phase) + 2'd1));

    // R5: a file write only happens in phase 3
    a_r5_we_in_q4: assert property (@(posedge clk) disable iff (rst)
        file_we |-> (phase == 2'd3));

    // R5: a skip request only happens in phase 3
    a_r5_skip_in_q4: assert property (@(posedge clk) disable iff (rst)
        skip_req |-> (phase == 2'd3));

    // R8: a no-operation cycle is quiet
    a_r8_nop_quiet: assert property (@(posedge clk) disable iff (rst)
        slot_nop |-> (!file_we && !skip_req));

    // R8: a skip is followed by a no-operation cycle
    a_r8_skip_then_nop: assert property (@(posedge clk) disable iff (rst)
        skip_req |=> (slot_nop && phase == 2'd0));

    // R2: the working register only changes at the end of phase 3
    a_r2_w_update_q4: assert property (@(posedge clk) disable iff (rst)
        (phase != 2'd3) |=> $stable(w_reg));
endmodule

bind incskip_exec incskip_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .phase    (phase),
    .slot_nop (slot_nop),
    .skip_req (skip_req),
    .file_we  (file_we),
    .w_reg    (w_reg)
);

// File: tb/incskip_exec_test.sv
`timescale 1ns/1ps
module incskip_exec_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] instr_word = 16'h0000;
    logic [3:0]  bank_sel = 4'h0;
    logic        ld_en = 1'b0;
    logic [11:0] ld_addr = 12'h000;
    logic [7:0]  ld_data = 8'h00;
    logic [1:0]  phase;
    logic        slot_nop, skip_req, file_we;
    logic [11:0] file_addr;
    logic [7:0]  file_wdata, w_reg;

    int n_chk = 0;
    int n_err = 0;
    logic done = 1'b0;

    logic [7:0] mdl [4096];
    logic [7:0] wexp = 8'h00;

    always #10 clk = ~clk;

    incskip_exec uut (
        .clk(clk), .rst(rst), .instr_word(instr_word), .bank_sel(bank_sel),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .phase(phase), .slot_nop(slot_nop), .skip_req(skip_req),
        .file_we(file_we), .file_addr(file_addr), .file_wdata(file_wdata),
        .w_reg(w_reg)
    );

    typedef struct packed {
        logic [15:0] word;
        logic [3:0]  bsr;
        logic [7:0]  pre;
        logic [11:0] addr;
        logic        skip;
        logic        we;
        logic [7:0]  val;
        logic        own;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{16'h3F10, 4'h3, 8'h05, 12'h310, 1'b0, 1'b1, 8'h06, 1'b1},
        '{16'h3F20, 4'h2, 8'hFF, 12'h220, 1'b1, 1'b1, 8'h00, 1'b1},
        '{16'h3C7F, 4'h9, 8'h41, 12'h07F, 1'b0, 1'b0, 8'h42, 1'b1},
        '{16'h3C80, 4'h9, 8'hFF, 12'hF80, 1'b1, 1'b0, 8'h00, 1'b1},
        '{16'h4A00, 4'h5, 8'h00, 12'h000, 1'b1, 1'b1, 8'h01, 1'b1},
        '{16'h4BFF, 4'hF, 8'hFF, 12'hFFF, 1'b0, 1'b1, 8'h00, 1'b1},
        '{16'h4933, 4'h1, 8'h7F, 12'h133, 1'b1, 1'b0, 8'h80, 1'b1},
        '{16'h3800, 4'h0, 8'h00, 12'h000, 1'b0, 1'b0, 8'h00, 1'b0},
        '{16'h4C00, 4'h0, 8'h00, 12'h000, 1'b0, 1'b0, 8'h00, 1'b0},
        '{16'h3E81, 4'h6, 8'h10, 12'hF81, 1'b0, 1'b1, 8'h11, 1'b1}
    };

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic poke(input logic [11:0] a, input logic [7:0] d);
        ld_en = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
        mdl[a] = d;
    endtask

    task automatic issue(input logic [15:0] w,
                         output logic nop_seen, output logic sk, output logic we,
                         output logic [11:0] ad, output logic [7:0] dt,
                         output logic [7:0] wv);
        while (phase != 2'd0) @(negedge clk);
        instr_word = w;
        nop_seen = slot_nop;
        repeat (3) @(negedge clk);
        sk = skip_req; we = file_we; ad = file_addr; dt = file_wdata;
        instr_word = 16'h0000;
        @(negedge clk);
        wv = w_reg;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic ns, sk, we;
        logic [11:0] ad;
        logic [7:0] dt, wv;

        for (int i = 0; i < 4096; i++) mdl[i] = 8'h00;

        repeat (3) @(negedge clk);
        chk("R10", "phase", phase, 0);
        chk("R10", "skip_req", skip_req, 0);
        chk("R10", "file_we", file_we, 0);
        chk("R10", "slot_nop", slot_nop, 0);
        chk("R10", "w_reg", w_reg, 0);
        rst = 1'b0;

        for (int i = 1; i <= 5; i++) begin
            @(negedge clk);
            chk("R5", "phase walk", phase, i % 4);
        end

        for (int i = 0; i < NV; i++) begin
            bank_sel = VECS[i].bsr;
            if (VECS[i].own) poke(VECS[i].addr, VECS[i].pre);
            issue(VECS[i].word, ns, sk, we, ad, dt, wv);
            chk("R8", "normal slot", ns, 0);
            chk(VECS[i].word[14] ? "R7" : "R6", "skip", sk, VECS[i].skip);
            if (!VECS[i].own) chk("R1", "no write", we, 0);
            else chk("R2", "file_we", we, VECS[i].we);
            if (VECS[i].own && VECS[i].we) begin
                chk(VECS[i].word[8] ? "R3" : "R4", "addr", ad, VECS[i].addr);
                chk("R2", "wdata", dt, VECS[i].val);
                mdl[VECS[i].addr] = VECS[i].val;
            end else if (VECS[i].own) begin
                wexp = VECS[i].val;
            end
            chk(VECS[i].own ? "R2" : "R1", "w_reg", wv, wexp);
            if (VECS[i].skip) begin
                issue(16'h0000, ns, sk, we, ad, dt, wv);
                chk("R8", "nop slot after skip", ns, 1);
            end
        end

        // two-word instruction skipped, its second word resembles an increment
        bank_sel = 4'h3;
        poke(12'h050, 8'hFF);
        issue(16'h3E50, ns, sk, we, ad, dt, wv);
        chk("R6", "wrap skip", sk, 1);
        chk("R4", "addr bank0", ad, 12'h050);
        mdl[12'h050] = 8'h00;
        issue(16'hC123, ns, sk, we, ad, dt, wv);
        chk("R8", "first nop", ns, 1);
        chk("R8", "first nop write", we, 0);
        issue(16'h3F10, ns, sk, we, ad, dt, wv);
        chk("R9", "second nop", ns, 1);
        chk("R9", "second word no write", we, 0);
        issue(16'h3F10, ns, sk, we, ad, dt, wv);
        chk("R9", "resume slot", ns, 0);
        chk("R9", "resume write", we, 1);
        chk("R9", "resume data", dt, mdl[12'h310] + 8'd1);
        mdl[12'h310] = mdl[12'h310] + 8'd1;

        // discarded one-word increment must not execute
        poke(12'h050, 8'hFF);
        issue(16'h3E50, ns, sk, we, ad, dt, wv);
        chk("R6", "skip again", sk, 1);
        issue(16'h3F10, ns, sk, we, ad, dt, wv);
        chk("R8", "discarded incr nop", ns, 1);
        chk("R8", "discarded incr write", we, 0);
        issue(16'h3D10, ns, sk, we, ad, dt, wv);
        chk("R8", "single nop only", ns, 0);
        chk("R8", "value untouched", wv, mdl[12'h310] + 8'd1);
        wexp = mdl[12'h310] + 8'd1;

        // two-word word after a non-skip is just another opcode
        issue(16'h3F10, ns, sk, we, ad, dt, wv);
        chk("R6", "no skip nonzero", sk, 0);
        mdl[12'h310] = mdl[12'h310] + 8'd1;
        issue(16'hC000, ns, sk, we, ad, dt, wv);
        chk("R9", "no nop without skip", ns, 0);
        chk("R1", "other opcode write", we, 0);
        chk("R1", "other opcode w", wv, wexp);

        // skip on non-zero into a two-word instruction
        poke(12'h010, 8'h01);
        issue(16'h4A10, ns, sk, we, ad, dt, wv);
        chk("R7", "nonzero skip", sk, 1);
        chk("R2", "nonzero data", dt, 8'h02);
        issue(16'hCFFF, ns, sk, we, ad, dt, wv);
        chk("R8", "nop one", ns, 1);
        issue(16'h0000, ns, sk, we, ad, dt, wv);
        chk("R9", "nop two", ns, 1);
        issue(16'h0000, ns, sk, we, ad, dt, wv);
        chk("R9", "back to normal", ns, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule